// File: doc/BRIEF.md
# Sign-Bit Pulse Width Modulator

This block drives one pulse-width-modulated output. It does not compare a counter against a threshold. Instead, a running accumulator advances by one on every clock. A period timer reloads it with the negated pulse width at the start of each period. The output is the accumulator's sign bit, so the pin stays high for exactly as many clocks as it takes the accumulator to climb from the loaded negative value back to zero. The shortest possible pulse is one clock.

Both the pulse width and the period length are given in clock cycles. The duty resolution therefore equals the period length in clocks. For example, an 80 MHz clock with a 256-cycle period gives 256 steps at 312.5 kHz, and a 20 kHz output from the same clock gives about 4000 steps. The block samples both settings only at a period boundary, so software or a control loop may rewrite them at any moment without a shortened or split pulse. Several outputs are made by instantiating the block several times.

Reset is asserted asynchronously and released through a synchronizer. The output is low throughout reset.

Top module: `phase_pwm`

## Requirements
- R1: While rst_n is low the output is low, and asserting rst_n low forces the output low without waiting for a clock edge.
- R2: After rst_n rises, the output stays low until the first period starts on the third rising clock edge (a two-stage release synchronizer followed by the reload).
- R3: Each period lasts P clocks. P is period_len, except that a period_len of 0 gives P = 1 and a period_len with bit 31 set gives P = 2^31 - 1.
- R4: Within a period the output is high for the first min(pulse_width, P) clocks and low for the rest. A pulse stays a single high run and never restarts inside a period.
- R5: A pulse_width of 0 keeps the output low for the whole period.
- R6: A pulse_width equal to or greater than P keeps the output high for the whole period. With P = 1 and a nonzero width the output is constantly high.
- R7: pulse_width and period_len are taken only at a period start. A change in mid-period alters neither the current pulse nor the current period length. A rising output edge only ever follows a period start.
- R8: A pulse_width of 1 gives a high time of exactly one clock per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pulse_width | input | 32 | Requested high time in clocks, taken at each period start |
| period_len | input | 32 | Period length in clocks, taken at each period start |
| pwm_out | output | 1 | Modulated output, the accumulator's sign bit |

## Verification
The first period starts on the third rising edge after reset release. From then on, each clock's output value follows directly from that period start: it appears one register after the reload edge, with no extra pipeline stage. The bench releases reset and changes inputs on falling edges. It samples the output on every falling edge and tracks the position of each sample inside the period, so every period is compared clock by clock with the expected high count and length. Mid-period changes are applied on a falling edge, and the checks expect them to take effect only from the next period index 0.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;
  // default data width of the accumulator and period register
  localparam int unsigned DEF_WIDTH = 32;
  // default number of flops in the reset release chain
  localparam int unsigned DEF_SYNC  = 2;
endpackage

// File: rtl/phase_pwm_rst_sync.sv
module phase_pwm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];

  AST_SYNC_HELD: assert property (@(posedge clk) !arst_n |-> !srst_n); // R1
endmodule

// File: rtl/phase_pwm_cfg.sv
module phase_pwm_cfg #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] width_in,
  input  logic [W-1:0] period_in,
  output logic [W-1:0] width_eff,
  output logic [W-1:0] period_eff
);
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  // period saturation keeps the loaded negative width representable
  always_comb begin
    if (period_in[W-1])      period_eff = MAXP;
    else if (period_in == '0) period_eff = ONE;
    else                      period_eff = period_in;
  end

  // width clamp keeps the accumulator from crossing zero twice
  always_comb begin
    if (width_in > period_eff) width_eff = period_eff;
    else                       width_eff = width_in;
  end
endmodule

// File: rtl/phase_pwm_timer.sv
module phase_pwm_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic [W-1:0] period_eff,
  output logic         reload
);
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MAXP = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] left_q;
  logic [W-1:0] left_d;
  logic         left_en;

  assign reload  = (left_q == '0);
  assign left_en = 1'b1;

  always_comb begin
    if (reload) left_d = period_eff - ONE;
    else        left_d = left_q - ONE;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  AST_LEFT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!srst_n)
    reload |=> (left_q < $past(period_eff))); // R3
  AST_LEFT_IN_RANGE: assert property (@(posedge clk) disable iff (!srst_n)
    left_q < MAXP); // R3
endmodule

// File: rtl/phase_pwm_acc.sv
module phase_pwm_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic         reload,
  input  logic [W-1:0] width_eff,
  output logic         sign_out
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] acc_q;
  logic [W-1:0] acc_d;
  logic         acc_en;

  assign acc_en = 1'b1;

  always_comb begin
    if (reload) acc_d = ~width_eff + ONE;
    else        acc_d = acc_q + ONE;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign sign_out = acc_q[W-1];

  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!srst_n)
    (!acc_q[W-1] && !reload) |=> !acc_q[W-1]); // R4
  AST_RISE_AT_LOAD: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(acc_q[W-1]) |-> $past(reload)); // R7
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!srst_n)
    (reload && width_eff == '0) |=> !acc_q[W-1]); // R5
endmodule

// File: rtl/phase_pwm.sv
module phase_pwm
  import phase_pwm_pkg::*;
#(
  parameter int unsigned W     = DEF_WIDTH,
  parameter int unsigned STAGES = DEF_SYNC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pulse_width,
  input  logic [W-1:0] period_len,
  output logic         pwm_out
);
  logic         srst_n;
  logic         reload;
  logic [W-1:0] width_eff;
  logic [W-1:0] period_eff;

  phase_pwm_rst_sync #(.STAGES(STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  phase_pwm_cfg #(.W(W)) u_cfg (
    .width_in   (pulse_width),
    .period_in  (period_len),
    .width_eff  (width_eff),
    .period_eff (period_eff)
  );

  phase_pwm_timer #(.W(W)) u_timer (
    .clk        (clk),
    .srst_n     (srst_n),
    .period_eff (period_eff),
    .reload     (reload)
  );

  phase_pwm_acc #(.W(W)) u_acc (
    .clk       (clk),
    .srst_n    (srst_n),
    .reload    (reload),
    .width_eff (width_eff),
    .sign_out  (pwm_out)
  );

  AST_RESET_LOW: assert property (@(posedge clk) !srst_n |-> !pwm_out); // R1
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!srst_n)
    (reload && width_eff == period_eff && width_eff != '0) |=> pwm_out); // R6
endmodule

// File: tb/sim_phase_pwm.sv
module sim_phase_pwm;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pulse_width;
  logic [31:0] period_len;
  logic        pwm_out;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk; // 50 MHz

  phase_pwm u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_width (pulse_width),
    .period_len  (period_len),
    .pwm_out     (pwm_out)
  );

  // fields: pulse_width, period_len, expected high clocks, expected period
  localparam int NV = 9;
  localparam logic [31:0] VTAB [NV][4] = '{
    '{32'd3,   32'd10,  32'd3,   32'd10},  // R4
    '{32'd0,   32'd8,   32'd0,   32'd8},   // R5
    '{32'd1,   32'd6,   32'd1,   32'd6},   // R8
    '{32'd12,  32'd12,  32'd12,  32'd12},  // R6
    '{32'd40,  32'd9,   32'd9,   32'd9},   // R6
    '{32'd5,   32'd0,   32'd1,   32'd1},   // R3 R6
    '{32'd0,   32'd1,   32'd0,   32'd1},   // R3 R5
    '{32'd255, 32'd256, 32'd255, 32'd256}, // R4
    '{32'd7,   32'd2,   32'd2,   32'd2}    // R6
  };

  task automatic check1(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // samples n falling edges, sample k holds period index start+k
  task automatic watch(input int n, input int start, input int hi, input string tag);
    int bad = 0;
    int first_j = -1;
    logic first_act = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out !== ((start + k) < hi)) begin
        if (bad == 0) begin
          first_j = start + k;
          first_act = pwm_out;
        end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s index %0d actual=%0b expected=%0b (%0d bad samples)",
               tag, first_j, first_act, (first_j < hi), bad);
    end
  endtask

  task automatic restart(input logic [31:0] pw, input logic [31:0] pl);
    @(negedge clk);
    rst_n = 1'b0;
    pulse_width = pw;
    period_len = pl;
    #1 check1(pwm_out, 1'b0, "R1 reset low");
    @(negedge clk);
    check1(pwm_out, 1'b0, "R1 reset held low");
    rst_n = 1'b1;
    watch(2, 0, 0, "R2 low before first period");
  endtask

  initial begin
    rst_n = 1'b0;
    pulse_width = '0;
    period_len = 32'd4;
    repeat (2) @(negedge clk);
    check1(pwm_out, 1'b0, "R1 power-up reset");

    // table of vectors, three periods each
    for (int i = 0; i < NV; i++) begin
      restart(VTAB[i][0], VTAB[i][1]);
      for (int p = 0; p < 3; p++)
        watch(int'(VTAB[i][3]), 0, int'(VTAB[i][2]), "R3 R4 period pattern");
    end

    // R7: width change mid-period only shows in the next period
    restart(32'd3, 32'd10);
    watch(4, 0, 3, "R7 before width change");
    pulse_width = 32'd8;
    watch(6, 4, 3, "R7 rest of old period");
    watch(10, 0, 8, "R7 new width next period");

    // R7: period change mid-period keeps the old length
    restart(32'd2, 32'd10);
    watch(5, 0, 2, "R7 before period change");
    period_len = 32'd4;
    watch(5, 5, 2, "R7 old period completes");
    watch(4, 0, 2, "R7 new period first");
    watch(4, 0, 2, "R7 new period second");

    // R3: bit 31 set saturates the period far beyond the window
    restart(32'd5, 32'hFFFF_FFF0);
    watch(200, 0, 5, "R3 saturated period");
    restart(32'h9000_0000, 32'hFFFF_FFFF);
    watch(100, 0, 1000, "R6 saturated width stays high");

    // R1: asynchronous reset in the middle of a high pulse
    restart(32'd20, 32'd40);
    watch(3, 0, 20, "R4 high before async reset");
    rst_n = 1'b0;
    #1 check1(pwm_out, 1'b0, "R1 async reset forces low");
    @(negedge clk);
    check1(pwm_out, 1'b0, "R1 stays low in reset");
    rst_n = 1'b1;
    watch(2, 0, 0, "R2 low after second release");
    watch(40, 0, 20, "R4 pattern after second release");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule